// File: doc/BRIEF.md
# Subnormal Single to Double Widener

This block turns a 32-bit single-precision subnormal operand into the equivalent 64-bit double-precision normal value. The double is returned as two 32-bit words, high and low. A start strobe captures the operand. The block then moves the fraction left one bit per clock and lowers a double-exponent counter on each move. It stops when the leading one reaches the implicit-bit position. It then drops that implicit bit and packs the sign, the exponent and the fraction into the two output words.

Only true subnormal operands are converted. Any other operand causes a one-cycle completion pulse with the write-enable held low, and the output words keep their earlier contents. The surrounding logic uses the write-enable to decide whether to store the word pair into a register pair.

Top module: `dnorm_widen`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `done_o` and `wr_en_o` are low, and both output words are zero.
- R2: An operand qualifies only when bits 30:23 are all zero and bits 22:0 are not all zero. A start with any other operand (normal, infinity, NaN, +0, or -0 = 0x80000000) raises `done_o` after the start edge with `wr_en_o` low. For such an operand `busy_o` is never set.
- R3: The exponent counter starts at 897. It drops by one on each shift, so the result exponent is 874 + p, where p is the index of the highest set bit of operand bits 22:0.
- R4: The high word carries the operand sign in bit 31 and the 11-bit exponent in bits 30:20. Bits 19:0 hold the normalised fraction bits 22:3, which are the bits left after the leading one is cleared.
- R5: The low word carries normalised fraction bits 2:0 in bits 31:29. Its bits 28:0 are zero.
- R6: Count the start edge as edge 1. For a qualifying operand, `done_o` and `wr_en_o` are seen after edge s+2, where s = 23 - p is the number of shifts. The worst case is 25 edges, for operand 0x00000001.
- R7: `done_o` and `wr_en_o` are single-cycle pulses, and `wr_en_o` is never high without `done_o`.
- R8: A start that arrives while `busy_o` is high is ignored. The conversion in progress finishes with its own operand and its own timing.
- R9: `busy_o` is high from the start edge of a qualifying operand until the edge that raises `done_o`. It is never high in the same cycle as `done_o`.
- R10: The output words change only on a cycle in which `wr_en_o` is high. Otherwise they hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| value_i | input | 32 | Single-precision operand |
| busy_o | output | 1 | Normalisation in progress |
| done_o | output | 1 | Completion pulse |
| wr_en_o | output | 1 | Result valid, store word pair |
| hi_word_o | output | 32 | Sign, exponent and upper fraction |
| lo_word_o | output | 32 | Lowest fraction bits, zero padded |

## Verification
The hardest case to reach from the ports is a second start strobe that lands inside a long normalisation. The bench sends operand 0x00000001, which needs 23 shifts. Several cycles later it pulses start again with a different qualifying operand and with a non-qualifying one. It then checks that the result and the 25-edge latency still belong to the first operand. The boundary operands cover both ends of the shift range, 0x00000001 and 0x007FFFFF. The rejected operands cover -0 and a normal value, and the bench checks that the words from the previous write are still held.

// File: rtl/dnw_pkg.sv
package dnw_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } dnw_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } dnw_words_t;
endpackage

// File: rtl/dnw_qualify.sv
module dnw_qualify #(
  parameter int SEXP_W = 8,
  parameter int FRAC_W = 23
) (
  input  logic [SEXP_W+FRAC_W-1:0] mag_i,
  output logic                     is_sub_o
);
  logic exp_zero, frac_nz;

  assign exp_zero = (mag_i[SEXP_W+FRAC_W-1 -: SEXP_W] == '0);
  assign frac_nz  = |mag_i[FRAC_W-1:0];
  assign is_sub_o = exp_zero & frac_nz;
endmodule

// File: rtl/dnw_norm.sv
module dnw_norm #(
  parameter int FRAC_W   = 23,
  parameter int DEXP_W   = 11,
  parameter int EXP_INIT = 897
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FRAC_W:0]   mant_o,
  output logic [DEXP_W-1:0] exp_o,
  output logic              lead_o
);
  localparam logic [DEXP_W-1:0] EXP_START = DEXP_W'(EXP_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_o <= '0;
      exp_o  <= '0;
    end else if (load_i) begin
      mant_o <= {1'b0, frac_i};
      exp_o  <= EXP_START;
    end else if (shift_i) begin
      mant_o <= {mant_o[FRAC_W-1:0], 1'b0};
      exp_o  <= exp_o - 1'b1;
    end
  end

  assign lead_o = mant_o[FRAC_W];
endmodule

// File: rtl/dnw_pack.sv
module dnw_pack
  import dnw_pkg::*;
#(
  parameter int FRAC_W = 23,
  parameter int DEXP_W = 11
) (
  input  logic              sign_i,
  input  logic [DEXP_W-1:0] exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output dnw_words_t        words_o
);
  localparam int DFRAC_W = 2*WORD_W - 1 - DEXP_W;
  localparam int PAD_W   = DFRAC_W - FRAC_W;
  localparam int HIFR_W  = WORD_W - 1 - DEXP_W;

  logic [DFRAC_W-1:0] frac_d;

  assign frac_d     = {frac_i, {PAD_W{1'b0}}};
  assign words_o.hi = {sign_i, exp_i, frac_d[DFRAC_W-1 -: HIFR_W]};
  assign words_o.lo = frac_d[WORD_W-1:0];
endmodule

// File: rtl/dnorm_widen.sv
module dnorm_widen
  import dnw_pkg::*;
#(
  parameter int FRAC_W = 23,
  parameter int SEXP_W = 8,
  parameter int DEXP_W = 11,
  parameter int DBIAS  = 1023
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [1+SEXP_W+FRAC_W-1:0]      value_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic                            wr_en_o,
  output logic [WORD_W-1:0]               hi_word_o,
  output logic [WORD_W-1:0]               lo_word_o
);
  localparam int SGL_W    = 1 + SEXP_W + FRAC_W;
  localparam int SBIAS    = (1 << (SEXP_W-1)) - 1;
  localparam int EXP_INIT = DBIAS - (SBIAS - 1);

  dnw_state_e        state_q;
  logic              sign_q;
  logic              is_sub, lead, load, shift;
  logic [FRAC_W:0]   mant;
  logic [DEXP_W-1:0] exp_cnt;
  dnw_words_t        packed_w;

  dnw_qualify #(.SEXP_W(SEXP_W), .FRAC_W(FRAC_W)) u_qual (
    .mag_i   (value_i[SGL_W-2:0]),
    .is_sub_o(is_sub)
  );

  assign load  = (state_q == ST_IDLE) && start_i && is_sub;
  assign shift = (state_q == ST_SHIFT) && !lead;

  dnw_norm #(.FRAC_W(FRAC_W), .DEXP_W(DEXP_W), .EXP_INIT(EXP_INIT)) u_norm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .frac_i (value_i[FRAC_W-1:0]),
    .mant_o (mant),
    .exp_o  (exp_cnt),
    .lead_o (lead)
  );

  // implicit leading one is dropped here
  dnw_pack #(.FRAC_W(FRAC_W), .DEXP_W(DEXP_W)) u_pack (
    .sign_i (sign_q),
    .exp_i  (exp_cnt),
    .frac_i (mant[FRAC_W-1:0]),
    .words_o(packed_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sign_q    <= 1'b0;
      done_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      hi_word_o <= '0;
      lo_word_o <= '0;
    end else begin
      done_o  <= 1'b0;
      wr_en_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (is_sub) begin
              state_q <= ST_SHIFT;
              sign_q  <= value_i[SGL_W-1];
            end else begin
              done_o <= 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (lead) begin
            state_q   <= ST_IDLE;
            done_o    <= 1'b1;
            wr_en_o   <= 1'b1;
            hi_word_o <= packed_w.hi;
            lo_word_o <= packed_w.lo;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_SHIFT);
endmodule

// File: rtl/dnw_checker.sv
module dnw_checker #(
  parameter int EXP_MIN = 874,
  parameter int EXP_MAX = 896
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [31:0] value_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        wr_en_o,
  input logic [31:0] hi_word_o,
  input logic [31:0] lo_word_o
);
  logic op_sub;
  assign op_sub = (value_i[30:23] == 8'h00) && (value_i[22:0] != '0);

  AST_WR_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_LO_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (lo_word_o[28:0] == '0)); // R5
  AST_EXP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((int'(hi_word_o[30:20]) >= EXP_MIN) && (int'(hi_word_o[30:20]) <= EXP_MAX))); // R3
  AST_WORDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(hi_word_o) || !$stable(lo_word_o)) |-> wr_en_o); // R10
  AST_BUSY_EXCL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R9
  AST_REJECT_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !op_sub) |=> (done_o && !wr_en_o && !busy_o)); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && op_sub) |=> busy_o); // R9
endmodule

bind dnorm_widen dnw_checker u_dnw_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .value_i  (value_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .wr_en_o  (wr_en_o),
  .hi_word_o(hi_word_o),
  .lo_word_o(lo_word_o)
);

// File: tb/dnorm_widen_tb_top.sv
module dnorm_widen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] value = '0;
  logic        busy, done, wr_en;
  logic [31:0] hi_w, lo_w;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] last_hi = '0;
  logic [31:0] last_lo = '0;

  always #10 clk = ~clk;

  dnorm_widen dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .value_i  (value),
    .busy_o   (busy),
    .done_o   (done),
    .wr_en_o  (wr_en),
    .hi_word_o(hi_w),
    .lo_word_o(lo_w)
  );

  localparam int NV = 10;
  localparam logic [31:0] V_IN [NV] = '{
    32'h0000_0001, 32'h807F_FFFF, 32'h3F80_0000, 32'h0040_0000, 32'h0000_0000,
    32'h0000_0007, 32'h8000_0000, 32'h0000_0003, 32'h7F80_0000, 32'h8001_2345};
  localparam logic [31:0] V_HI [NV] = '{
    32'h36A0_0000, 32'hB80F_FFFF, 32'h0, 32'h3800_0000, 32'h0,
    32'h36CC_0000, 32'h0, 32'h36B8_0000, 32'h0, 32'hB7A2_3450};
  localparam logic [31:0] V_LO [NV] = '{
    32'h0, 32'hC000_0000, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic V_WR [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int   V_CY [NV] = '{25, 3, 1, 3, 1, 23, 1, 24, 1, 9};

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // drive start at a falling edge; returns edges until done seen
  task automatic run_op(input logic [31:0] v, input logic [31:0] e_hi, input logic [31:0] e_lo,
                        input logic e_wr, input int e_cy, input int spur_at);
    int cyc;
    logic [31:0] want_hi, want_lo;
    @(negedge clk);
    value = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy == e_wr, "R9/R2 busy after start edge", 32'(busy), 32'(e_wr));
    while (!done && cyc < 100) begin
      if (cyc == spur_at) begin
        value = 32'h0040_0000;
        start = 1'b1;
      end else if (cyc == spur_at + 1) begin
        value = 32'h3F80_0000;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (!done) chk(busy == 1'b1, "R8/R9 busy held during run", 32'(busy), 32'h1);
    end
    want_hi = e_wr ? e_hi : last_hi;
    want_lo = e_wr ? e_lo : last_lo;
    chk(cyc == e_cy, "R6 latency", 32'(cyc), 32'(e_cy));
    chk(wr_en == e_wr, "R2 write enable", 32'(wr_en), 32'(e_wr));
    chk(hi_w == want_hi, e_wr ? "R3/R4 high word" : "R10 high word held", hi_w, want_hi);
    chk(lo_w == want_lo, e_wr ? "R5 low word" : "R10 low word held", lo_w, want_lo);
    chk(busy == 1'b0, "R9 busy low with done", 32'(busy), 32'h0);
    if (e_wr) begin
      last_hi = e_hi;
      last_lo = e_lo;
    end
    @(negedge clk);
    chk(!done && !wr_en, "R7 single-cycle pulse", {30'b0, done, wr_en}, 32'h0);
    chk(hi_w == last_hi, "R10 words hold after pulse", hi_w, last_hi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #5;
    chk({busy, done, wr_en} == 3'b000, "R1 control in reset", {29'b0, busy, done, wr_en}, 32'h0);
    chk(hi_w == 0 && lo_w == 0, "R1 words in reset", hi_w | lo_w, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, wr_en} == 3'b000, "R1 control after reset", {29'b0, busy, done, wr_en}, 32'h0);
    chk(hi_w == 0 && lo_w == 0, "R1 words after reset", hi_w | lo_w, 32'h0);

    for (int i = 0; i < NV; i++) run_op(V_IN[i], V_HI[i], V_LO[i], V_WR[i], V_CY[i], -1);

    // R8: long run with spurious starts mid-way
    run_op(32'h0000_0001, 32'h36A0_0000, 32'h0, 1'b1, 25, 4);
    // R2 boundary: largest subnormal after a rejection keeps words
    run_op(32'h0080_0000, 32'h0, 32'h0, 1'b0, 1, -1);
    run_op(32'h007F_FFFF, 32'h380F_FFFF, 32'hC000_0000, 1'b1, 3, -1);

    // R1: reset mid-run clears everything
    @(negedge clk);
    value = 32'h0000_0001;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({busy, done, wr_en} == 3'b000 && hi_w == 0, "R1 reset mid-run", hi_w, 32'h0);
    rst_n = 1'b1;
    last_hi = '0;
    last_lo = '0;
    run_op(32'h0000_0003, 32'h36B8_0000, 32'h0, 1'b1, 24, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule